// File: doc/BRIEF.md
# MDIO Management Frame Target Decoder

This block is the PHY-side decoder for a clause-22 serial management frame. The management clock and data lines are not free-running. A host toggles them by writing levels into a register, and this block sees them only as slow level inputs. A fast system clock samples them, and every change of the management clock level counts as one half bit period. From these half periods the block tracks the preamble, the start pattern, the opcode, the PHY address, the register number and the turnaround. It then either collects sixteen write-data bits or shifts out sixteen read-data bits.

Only one PHY sits behind the decoder, at a parameterised address (default 1). For that address, a completed write frame raises a one-cycle write strobe toward a PHY register port, and a read frame fetches that port's value at the end of turnaround. For any other address, reads return all ones and writes are dropped. The line level, whether driven by the target or by the host, is always available as a status bit.

Top module: `mdio_mgmt_target`

## Requirements
- R1: After reset, mdio_oe, mdio_out, reg_wr, reg_rd and start_warn are all 0, and the decoder waits in preamble.
- R2: A frame begins only on a rising management-clock edge that samples MDIO low, and only once at least 64 clock-level transitions (counting that edge) have occurred in preamble. From reset, 31 one-bits followed by a zero do not start a frame.
- R3: Fields are sampled on rising edges, MSB first: opcode (2 bits), PHY address (5 bits), register number (5 bits). A write frame to address 1 pulses reg_wr for one system clock after the 16th data bit, with reg_num and reg_wdata (MSB received first) valid.
- R4: With opcode 2'b10, mdio_oe rises at the end of the second turnaround bit. Read data bits are then placed on mdio_out on falling edges, bit 15 first, one per bit period.
- R5: A read to any address other than 1 returns 16'hFFFF and raises no reg_rd. A write to such an address raises no reg_wr.
- R6: If the second start bit samples 0, start_warn pulses for one system clock and the frame is still decoded and carried out.
- R7: Every opcode other than 2'b10 (2'b00, 2'b01, 2'b11) completes as a write.
- R8: mdio_level equals mdio_out while mdio_oe is 1, and equals mdio_in otherwise.
- R9: mdio_oe falls on the rising edge that ends the 16th data bit, and the decoder returns to preamble, so a following frame needs a fresh preamble.
- R10: A read to address 1 pulses reg_rd for one system clock at the fetch, with reg_num holding the register number. reg_wr and reg_rd are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the management lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_lvl | input | 1 | Management clock level written by the host |
| mdio_in | input | 1 | Data level driven by the host |
| mdio_oe | output | 1 | Target drives the data line (read data phase) |
| mdio_out | output | 1 | Data bit driven by the target |
| mdio_level | output | 1 | Resolved data line level, readable as status |
| start_warn | output | 1 | One-cycle pulse on a bad second start bit |
| reg_num | output | 5 | Register number of the current frame |
| reg_wdata | output | 16 | Write data, valid with reg_wr |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 16 | Register value of the PHY for reg_num |

## Verification
The bench drives a preamble one bit too short from reset. A decoder with the threshold off by one would start a normal read there and drive the line, while the correct one starts late, warns and stays silent. Reads to unoccupied addresses and writes with the opcodes 2'b00 and 2'b11 are aimed at decoders that return stale register contents or treat only 2'b01 as a write. Each read bit is sampled just before the rising edge. A decoder that shifts one edge early or late returns data rotated by one bit, and one that keeps driving after the 16th bit shows up in the check of mdio_oe after the frame.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

    typedef enum logic [2:0] {
        FLD_IDLE,
        FLD_START,
        FLD_OP,
        FLD_PHY,
        FLD_REG,
        FLD_TURN,
        FLD_DATA
    } mdio_fld_e;

    localparam logic [1:0] OPC_READ = 2'b10;
    localparam int START_BITS = 1;
    localparam int OPC_BITS   = 2;
    localparam int TURN_BITS  = 2;

endpackage

// File: rtl/mdio_mdc_edge.sv
module mdio_mdc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_lvl,
    output logic rise,
    output logic fall
);

    logic mdc_d, mdc_q;

    always_comb begin
        mdc_d = mdc_lvl;
        rise  = mdc_lvl & ~mdc_q;
        fall  = ~mdc_lvl & mdc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdc_q <= 1'b0;
        else        mdc_q <= mdc_d;
    end

endmodule

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
    import mdio_tgt_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PHY_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_in,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              drive,
    output logic              drive_bit,
    output logic              warn,
    output logic [ADDR_W-1:0] reg_num,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd
);

    localparam int PRE_HALF  = 2 * PRE_BITS;
    localparam int CNT_W     = $clog2(PRE_HALF + 1) + 1;
    localparam int SOF_HALF  = 2 * START_BITS;
    localparam int OPC_HALF  = 2 * OPC_BITS;
    localparam int ADDR_HALF = 2 * ADDR_W;
    localparam int TURN_HALF = 2 * TURN_BITS;
    localparam int DATA_HALF = 2 * DATA_W;
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PHY_ADDR);

    typedef struct packed {
        mdio_fld_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        opc;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] shreg;
        logic              drive;
        logic              out;
        logic              wr;
        logic              rd;
        logic              warn;
    } dec_s;

    dec_s d, q;
    logic [CNT_W-1:0] cnt_inc;
    logic             addr_hit;

    always_comb begin
        d        = q;
        d.wr     = 1'b0;
        d.rd     = 1'b0;
        d.warn   = 1'b0;
        cnt_inc  = (q.cnt == CNT_MAX) ? q.cnt : q.cnt + 1'b1;
        addr_hit = (q.phy == MY_ADDR);
        if (rise || fall) begin
            d.cnt = cnt_inc;
            unique case (q.st)
                FLD_IDLE: begin
                    if (rise && !mdio_in && cnt_inc >= CNT_W'(PRE_HALF)) begin
                        d.st  = FLD_START;
                        d.cnt = '0;
                    end
                end
                FLD_START: begin
                    if (rise) begin
                        d.warn = ~mdio_in;
                        if (cnt_inc == CNT_W'(SOF_HALF)) begin
                            d.st  = FLD_OP;
                            d.cnt = '0;
                            d.opc = '0;
                        end
                    end
                end
                FLD_OP: begin
                    if (rise) begin
                        d.opc = {q.opc[0], mdio_in};
                        if (cnt_inc == CNT_W'(OPC_HALF)) begin
                            d.st  = FLD_PHY;
                            d.cnt = '0;
                            d.phy = '0;
                        end
                    end
                end
                FLD_PHY: begin
                    if (rise) begin
                        d.phy = {q.phy[ADDR_W-2:0], mdio_in};
                        if (cnt_inc == CNT_W'(ADDR_HALF)) begin
                            d.st   = FLD_REG;
                            d.cnt  = '0;
                            d.regn = '0;
                        end
                    end
                end
                FLD_REG: begin
                    if (rise) begin
                        d.regn = {q.regn[ADDR_W-2:0], mdio_in};
                        if (cnt_inc == CNT_W'(ADDR_HALF)) begin
                            d.st  = FLD_TURN;
                            d.cnt = '0;
                        end
                    end
                end
                FLD_TURN: begin
                    if (rise && cnt_inc == CNT_W'(TURN_HALF)) begin
                        d.st  = FLD_DATA;
                        d.cnt = '0;
                        d.out = 1'b0;
                        if (q.opc == OPC_READ) begin
                            d.drive = 1'b1;
                            d.rd    = addr_hit;
                            d.shreg = addr_hit ? reg_rdata : '1;
                        end
                    end
                end
                FLD_DATA: begin
                    if (fall && q.drive) begin
                        d.out   = q.shreg[DATA_W-1];
                        d.shreg = {q.shreg[DATA_W-2:0], 1'b0};
                    end
                    if (rise) begin
                        if (!q.drive) d.shreg = {q.shreg[DATA_W-2:0], mdio_in};
                        if (cnt_inc == CNT_W'(DATA_HALF)) begin
                            d.st    = FLD_IDLE;
                            d.cnt   = '0;
                            d.wr    = ~q.drive & addr_hit;
                            d.drive = 1'b0;
                            d.out   = 1'b0;
                        end
                    end
                end
                default: d.st = FLD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= FLD_IDLE;
        end else begin
            q <= d;
        end
    end

    assign drive     = q.drive;
    assign drive_bit = q.out;
    assign warn      = q.warn;
    assign reg_num   = q.regn;
    assign reg_wdata = q.shreg;
    assign reg_wr    = q.wr;
    assign reg_rd    = q.rd;

    // R4: the line is driven only inside the data field
    a_r4_drive_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        q.drive |-> q.st == FLD_DATA);
    // R4: driving starts only for a read opcode
    a_r4_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.drive) |-> q.opc == OPC_READ);
    // R5: write strobes only for the attached address
    a_r5_wr_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> q.phy == MY_ADDR);
    // R10: read and write strobes exclusive
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.wr && q.rd));
    // R9: release of the line coincides with the return to preamble
    a_r9_release_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.drive) |-> q.st == FLD_IDLE);
    // R3: field counters stay within the longest field
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != FLD_IDLE) |-> q.cnt <= CNT_W'(DATA_HALF));
    // R6: warning is a single-cycle pulse
    a_r6_warn_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.warn |=> !q.warn);

endmodule

// File: rtl/mdio_mgmt_target.sv
module mdio_mgmt_target #(
    parameter int PRE_BITS = 32,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PHY_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_lvl,
    input  logic              mdio_in,
    output logic              mdio_oe,
    output logic              mdio_out,
    output logic              mdio_level,
    output logic              start_warn,
    output logic [ADDR_W-1:0] reg_num,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic rise, fall;

    mdio_mdc_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc_lvl (mdc_lvl),
        .rise    (rise),
        .fall    (fall)
    );

    mdio_frame_decoder #(
        .PRE_BITS (PRE_BITS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PHY_ADDR (PHY_ADDR)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .mdio_in   (mdio_in),
        .reg_rdata (reg_rdata),
        .drive     (mdio_oe),
        .drive_bit (mdio_out),
        .warn      (start_warn),
        .reg_num   (reg_num),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd)
    );

    assign mdio_level = mdio_oe ? mdio_out : mdio_in;

    // R8: resolved level follows the host while the target is silent
    a_r8_level_host: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe |-> mdio_level == mdio_in);

endmodule

// File: tb/mdio_mgmt_target_test.sv
module mdio_mgmt_target_test;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc_lvl = 1'b0;
    logic mdio_in = 1'b1;
    logic mdio_oe, mdio_out, mdio_level, start_warn, reg_wr, reg_rd;
    logic [4:0]  reg_num;
    logic [15:0] reg_wdata, reg_rdata;

    logic [15:0] phy_mem [32];
    logic [15:0] exp_mem [32];

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, rd_cnt = 0, warn_cnt = 0, oe_rise_cnt = 0;
    logic [4:0]  last_wr_reg;
    logic [15:0] last_wr_data;
    logic [4:0]  last_rd_reg;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign reg_rdata = phy_mem[reg_num];

    mdio_mgmt_target uut (
        .clk(clk), .rst_n(rst_n), .mdc_lvl(mdc_lvl), .mdio_in(mdio_in),
        .mdio_oe(mdio_oe), .mdio_out(mdio_out), .mdio_level(mdio_level),
        .start_warn(start_warn), .reg_num(reg_num), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    initial begin
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'h5A00 ^ 16'(i * 16'h0111);
    end

    always @(negedge clk) begin
        if (reg_wr) begin
            wr_cnt++;
            last_wr_reg  = reg_num;
            last_wr_data = reg_wdata;
            phy_mem[reg_num] = reg_wdata;
        end
        if (reg_rd) begin
            rd_cnt++;
            last_rd_reg = reg_num;
        end
        if (start_warn) warn_cnt++;
        if (mdio_oe && !oe_prev) oe_rise_cnt++;
        oe_prev = mdio_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] phy, input logic [4:0] rg);
        return (phy == 5'd1) ? exp_mem[rg] : 16'hFFFF;
    endfunction

    function automatic bit is_write(input logic [1:0] op);
        return op != 2'b10;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); mdio_in = b; mdc_lvl = 1'b0;
        repeat (HOLD) @(negedge clk);
        mdc_lvl = 1'b1;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic do_frame(input int npre, input logic sbit, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                            output logic [15:0] rv, output logic oe_ta, output int oe_bad,
                            output int lvl_bad, output logic oe_after);
        rv = '0; oe_bad = 0; lvl_bad = 0;
        for (int i = 0; i < npre; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(sbit);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(rg[i]);
        send_bit(1'b1);
        send_bit(1'b1);
        oe_ta = mdio_oe;
        for (int i = 15; i >= 0; i--) begin
            if (is_write(op)) begin
                send_bit(wd[i]);
            end else begin
                @(negedge clk); mdio_in = 1'b1; mdc_lvl = 1'b0;
                repeat (HOLD) @(negedge clk);
                rv[i] = mdio_out;
                if (!mdio_oe) oe_bad++;
                if (mdio_level !== mdio_out) lvl_bad++;
                mdc_lvl = 1'b1;
                repeat (HOLD) @(negedge clk);
            end
        end
        oe_after = mdio_oe;
    endtask

    task automatic run_write(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic sbit, input string tag);
        logic [15:0] rv; logic oe_ta, oe_after; int oe_bad, lvl_bad;
        int w0 = wr_cnt;
        do_frame(32, sbit, op, phy, rg, wd, rv, oe_ta, oe_bad, lvl_bad, oe_after);
        if (phy == 5'd1) begin
            chk(wr_cnt == w0 + 1, {tag, " write strobe count"}, wr_cnt - w0, 1);
            chk(last_wr_reg == rg && last_wr_data == wd, {tag, " write reg/data"},
                {11'd0, last_wr_reg, last_wr_data}, {11'd0, rg, wd});
            exp_mem[rg] = wd;
        end else begin
            chk(wr_cnt == w0, "R5 write to other address dropped", wr_cnt - w0, 0);
        end
        chk(!oe_ta && !oe_after, {tag, " no drive in write"}, {oe_ta, oe_after}, 0);
    endtask

    task automatic run_read(input logic [4:0] phy, input logic [4:0] rg);
        logic [15:0] rv; logic oe_ta, oe_after; int oe_bad, lvl_bad;
        int r0 = rd_cnt;
        logic [15:0] e = exp_read(phy, rg);
        do_frame(32, 1'b1, 2'b10, phy, rg, 16'h0, rv, oe_ta, oe_bad, lvl_bad, oe_after);
        chk(rv == e, (phy == 5'd1) ? "R4 read data" : "R5 read other address all ones", rv, e);
        chk(oe_ta && oe_bad == 0, "R4 drive through data field", {oe_ta, 16'(oe_bad)}, 32'h10000);
        chk(lvl_bad == 0, "R8 level follows driven bit", lvl_bad, 0);
        chk(!oe_after, "R9 release after 16th bit", oe_after, 0);
        if (phy == 5'd1)
            chk(rd_cnt == r0 + 1 && last_rd_reg == rg, "R10 read strobe and reg_num",
                {rd_cnt - r0, 27'(last_rd_reg)}, {32'd1, 27'(rg)});
        else
            chk(rd_cnt == r0, "R5 no read strobe for other address", rd_cnt - r0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [15:0] rv; logic oe_ta, oe_after; int oe_bad, lvl_bad;
        int w0, r0, k0;
        for (int i = 0; i < 32; i++) exp_mem[i] = 16'h5A00 ^ 16'(i * 16'h0111);
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk(!mdio_oe && !mdio_out && !reg_wr && !reg_rd && !start_warn, "R1 reset outputs",
            {mdio_oe, mdio_out, reg_wr, reg_rd, start_warn}, 0);
        chk(mdio_level == mdio_in, "R1 R8 level after reset", mdio_level, mdio_in);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: 31 ones from reset is one transition short; late start sees a bad start bit
        w0 = wr_cnt; r0 = rd_cnt; k0 = warn_cnt;
        do_frame(31, 1'b1, 2'b10, 5'd1, 5'd0, 16'h0, rv, oe_ta, oe_bad, lvl_bad, oe_after);
        chk(oe_rise_cnt == 0 && !oe_ta, "R2 short preamble does not start read", oe_rise_cnt, 0);
        chk(rd_cnt == r0, "R2 no read strobe on short preamble", rd_cnt - r0, 0);
        idle(40);
        chk(wr_cnt == w0 && warn_cnt == k0 + 1, "R2 late start only warns",
            {wr_cnt - w0, warn_cnt - k0}, 1);

        run_write(2'b01, 5'd1, 5'd4, 16'hBEEF, 1'b1, "R3");
        run_read(5'd1, 5'd4);
        run_write(2'b01, 5'd1, 5'd0, 16'h8001, 1'b1, "R3");
        run_read(5'd1, 5'd0);
        run_write(2'b01, 5'd1, 5'd31, 16'h0000, 1'b1, "R3");
        run_read(5'd1, 5'd31);
        run_read(5'd7, 5'd4);
        run_read(5'd0, 5'd2);
        run_write(2'b01, 5'd9, 5'd5, 16'h1234, 1'b1, "R5");
        run_read(5'd1, 5'd5);
        run_write(2'b00, 5'd1, 5'd6, 16'hA5C3, 1'b1, "R7 opcode 00");
        run_write(2'b11, 5'd1, 5'd7, 16'h3C5A, 1'b1, "R7 opcode 11");
        run_read(5'd1, 5'd6);

        k0 = warn_cnt;
        run_write(2'b01, 5'd1, 5'd12, 16'h0F0F, 1'b0, "R6 bad start");
        chk(warn_cnt == k0 + 1, "R6 start warning pulse", warn_cnt - k0, 1);

        for (int n = 0; n < 24; n++) begin
            logic [4:0] phy = ($urandom % 4 == 0) ? 5'($urandom) : 5'd1;
            logic [4:0] rg = 5'($urandom);
            if ($urandom % 2 == 0) run_write(2'b01, phy, rg, 16'($urandom), 1'b1, "R3 random");
            else run_read(phy, rg);
        end

        chk(!reg_wr && !reg_rd, "R10 strobes idle", {reg_wr, reg_rd}, 0);
        finish_run();
    end

endmodule